// File: doc/BRIEF.md
# Split Access Completion Tracker

This block follows one memory access from acceptance to completion. An access may be split into a low part and a high part because it crosses an alignment boundary. The caller supplies the base address, the total byte count and the byte count of the low part. The block sends the low request to the cache, then the high request on the next cycle. It merges the bytes that come back into one buffer and reports completion once no part is still outstanding.

The block keeps a count of outstanding parts: one for a plain access, two for a split one. Each response lowers the count by one. A refused low request drops the whole access. A refused high request drops only that part: the count falls by one and the access completes on the low response alone. Both kinds of refusal raise a retry pulse, so that the caller can restart the access later.

Top module: `split_access_tracker`

## Requirements
- R1: While reset is asserted and after it is released, `acc_ready` is 1 and `req_valid`, `done_valid` and `retry` are 0. A reset in the middle of an access returns the block to this idle state.
- R2: An access offered while `acc_ready` is 1 is taken at that clock edge. On the next cycle `req_valid` is 1 with `req_addr` equal to the base address. `req_size` is the low size when `acc_lo_size` is nonzero, and the total size when it is 0 (0 means unsplit). While busy, `acc_ready` is 0 and offered accesses are ignored.
- R3: For a split access, the high request follows only after the low request was accepted, on the next cycle, with `req_addr` = base + low size and `req_size` = total − low size. At most one request is sent per cycle.
- R4: A response with `rsp_part` = 0 (low) writes its bytes 0 .. low length−1 to buffer bytes 0 upward. A response with `rsp_part` = 1 (high) writes its bytes 0 .. high length−1 to buffer bytes starting at the low size. Response bytes beyond the part's length are ignored, and buffer bytes that no response writes read as 0.
- R5: If the low request is refused (`req_valid` = 1, `req_accept` = 0), the access is dropped and `done_valid` never pulses for it. `retry` pulses on the next cycle, and `acc_ready` is 1 again on that cycle.
- R6: If the high request is refused, `retry` pulses on the next cycle. The access completes after the low response alone, with `done_partial` = 1 and only the low bytes in `done_data`.
- R7: `done_valid` pulses for exactly one cycle, on the cycle after the last outstanding response. It carries `done_tag` equal to the access tag and `done_partial` = 0 when both parts returned. It never pulses earlier. Responses may come in either order, and the low response may arrive on the same cycle as the high send.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | Access offered |
| acc_ready | output | 1 | Block idle, access can be taken |
| acc_addr | input | ADDR_W | Base byte address of the access |
| acc_tag | input | TAG_W | Identifier returned on completion |
| acc_size | input | SIZE_W | Total access size in bytes |
| acc_lo_size | input | SIZE_W | Low part size in bytes, 0 for unsplit |
| req_valid | output | 1 | Cache request sent this cycle |
| req_addr | output | ADDR_W | Request byte address |
| req_size | output | SIZE_W | Request size in bytes |
| req_accept | input | 1 | Cache takes the request this cycle |
| rsp_valid | input | 1 | Response data present |
| rsp_part | input | 1 | 0 = low part, 1 = high part |
| rsp_data | input | DATA_W | Response bytes, part byte 0 in bits 7:0 |
| done_valid | output | 1 | One-cycle completion pulse |
| done_tag | output | TAG_W | Tag of the completed access |
| done_data | output | DATA_W | Assembled bytes |
| done_partial | output | 1 | High part was dropped |
| retry | output | 1 | One-cycle pulse after a refused request |

## Verification
The bench builds the block with the default values: 8-byte buffer, 4-bit tag and 16-bit address. With these values every split point from one to seven low bytes is reachable, as are full-width plain accesses and high parts placed at odd offsets. Response words carry filler bytes above each part's length, which exposes any write past a part boundary. The bench covers refusal of either part, high-first return order, and a low response that coincides with a refused high send, which drops the count by two in one cycle.

// File: rtl/sat_pkg.sv
package sat_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_SEND_LO = 2'd1,
    ST_SEND_HI = 2'd2,
    ST_WAIT    = 2'd3
  } sat_state_e;

  localparam int MAX_PARTS = 2;
  localparam int CNT_W     = $clog2(MAX_PARTS + 1);
  localparam logic PART_LO = 1'b0;
  localparam logic PART_HI = 1'b1;
endpackage

// File: rtl/sat_part_count.sv
module sat_part_count
  import sat_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic load_two,
  input  logic clear,
  input  logic dec_rsp,
  input  logic dec_drop,
  output logic next_zero
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    if (load)       cnt_d = load_two ? CNT_W'(MAX_PARTS) : CNT_W'(1);
    else if (clear) cnt_d = '0;
    else            cnt_d = cnt_q - CNT_W'(dec_rsp) - CNT_W'(dec_drop);
    cnt_en    = load | clear | dec_rsp | dec_drop;
    next_zero = (cnt_d == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/sat_byte_merge.sv
module sat_byte_merge #(
  parameter int DATA_BYTES = 8,
  parameter int SIZE_W     = $clog2(DATA_BYTES + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clear,
  input  logic                    rsp_valid,
  input  logic                    rsp_hi,
  input  logic [SIZE_W-1:0]       lo_off,
  input  logic [SIZE_W-1:0]       lo_len,
  input  logic [SIZE_W-1:0]       total,
  input  logic [DATA_BYTES*8-1:0] rsp_data,
  output logic [DATA_BYTES*8-1:0] buf_q
);
  localparam int DATA_W = DATA_BYTES * 8;

  logic [DATA_W-1:0] placed;

  always_comb begin
    placed = rsp_hi ? (rsp_data << {lo_off, 3'b000}) : rsp_data;
  end

  for (genvar j = 0; j < DATA_BYTES; j++) begin : g_byte
    localparam logic [SIZE_W-1:0] IDX = SIZE_W'(j);
    logic wr;

    always_comb begin
      if (rsp_hi) wr = rsp_valid && (IDX >= lo_off) && (IDX < total);
      else        wr = rsp_valid && (IDX < lo_len);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     buf_q[j*8 +: 8] <= '0;
      else if (clear) buf_q[j*8 +: 8] <= '0;
      else if (wr)    buf_q[j*8 +: 8] <= placed[j*8 +: 8];
    end
  end
endmodule

// File: rtl/sat_issue_ctrl.sv
module sat_issue_ctrl
  import sat_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic acc_valid,
  input  logic acc_split,
  input  logic req_accept,
  input  logic cnt_next_zero,
  output logic acc_ready,
  output logic req_valid,
  output logic req_hi,
  output logic take,
  output logic drop_lo,
  output logic drop_hi,
  output logic done_q,
  output logic retry_q,
  output logic partial_q
);
  sat_state_e state_q, state_d;
  logic       split_q;
  logic       fin;

  always_comb begin
    state_d = state_q;
    take    = 1'b0;
    drop_lo = 1'b0;
    drop_hi = 1'b0;
    fin     = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (acc_valid) begin
          take    = 1'b1;
          state_d = ST_SEND_LO;
        end
      end
      ST_SEND_LO: begin
        if (!req_accept) begin
          drop_lo = 1'b1;
          state_d = ST_IDLE;
        end else begin
          state_d = split_q ? ST_SEND_HI : ST_WAIT;
        end
      end
      ST_SEND_HI: begin
        drop_hi = !req_accept;
        if (cnt_next_zero) begin
          fin     = 1'b1;
          state_d = ST_IDLE;
        end else begin
          state_d = ST_WAIT;
        end
      end
      ST_WAIT: begin
        if (cnt_next_zero) begin
          fin     = 1'b1;
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
    acc_ready = (state_q == ST_IDLE);
    req_valid = (state_q == ST_SEND_LO) || (state_q == ST_SEND_HI);
    req_hi    = (state_q == ST_SEND_HI);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      split_q   <= 1'b0;
      partial_q <= 1'b0;
      done_q    <= 1'b0;
      retry_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= fin;
      retry_q <= drop_lo | drop_hi;
      if (take) begin
        split_q   <= acc_split;
        partial_q <= 1'b0;
      end else if (drop_hi) begin
        partial_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/split_access_tracker.sv
module split_access_tracker
  import sat_pkg::*;
#(
  parameter int DATA_BYTES = 8,
  parameter int TAG_W      = 4,
  parameter int ADDR_W     = 16,
  parameter int SIZE_W     = $clog2(DATA_BYTES + 1),
  parameter int DATA_W     = DATA_BYTES * 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  output logic              acc_ready,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [TAG_W-1:0]  acc_tag,
  input  logic [SIZE_W-1:0] acc_size,
  input  logic [SIZE_W-1:0] acc_lo_size,
  output logic              req_valid,
  output logic [ADDR_W-1:0] req_addr,
  output logic [SIZE_W-1:0] req_size,
  input  logic              req_accept,
  input  logic              rsp_valid,
  input  logic              rsp_part,
  input  logic [DATA_W-1:0] rsp_data,
  output logic              done_valid,
  output logic [TAG_W-1:0]  done_tag,
  output logic [DATA_W-1:0] done_data,
  output logic              done_partial,
  output logic              retry
);
  logic [ADDR_W-1:0] base_q;
  logic [TAG_W-1:0]  tag_q;
  logic [SIZE_W-1:0] size_q, lo_q, lo_len;
  logic              take, drop_lo, drop_hi, req_hi, cnt_next_zero;

  sat_issue_ctrl u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .acc_valid    (acc_valid),
    .acc_split    (acc_lo_size != '0),
    .req_accept   (req_accept),
    .cnt_next_zero(cnt_next_zero),
    .acc_ready    (acc_ready),
    .req_valid    (req_valid),
    .req_hi       (req_hi),
    .take         (take),
    .drop_lo      (drop_lo),
    .drop_hi      (drop_hi),
    .done_q       (done_valid),
    .retry_q      (retry),
    .partial_q    (done_partial)
  );

  sat_part_count u_count (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (take),
    .load_two (acc_lo_size != '0),
    .clear    (drop_lo),
    .dec_rsp  (rsp_valid && !acc_ready),
    .dec_drop (drop_hi),
    .next_zero(cnt_next_zero)
  );

  sat_byte_merge #(.DATA_BYTES(DATA_BYTES), .SIZE_W(SIZE_W)) u_merge (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (take),
    .rsp_valid(rsp_valid && !acc_ready),
    .rsp_hi   (rsp_part == PART_HI),
    .lo_off   (lo_q),
    .lo_len   (lo_len),
    .total    (size_q),
    .rsp_data (rsp_data),
    .buf_q    (done_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      tag_q  <= '0;
      size_q <= '0;
      lo_q   <= '0;
    end else if (take) begin
      base_q <= acc_addr;
      tag_q  <= acc_tag;
      size_q <= acc_size;
      lo_q   <= acc_lo_size;
    end
  end

  always_comb begin
    lo_len   = (lo_q == '0) ? size_q : lo_q;
    req_addr = req_hi ? (base_q + ADDR_W'(lo_q)) : base_q;
    req_size = req_hi ? (size_q - lo_q) : lo_len;
    done_tag = tag_q;
  end
endmodule

// File: rtl/sat_checker.sv
module sat_checker (
  input logic clk,
  input logic rst_n,
  input logic acc_ready,
  input logic req_valid,
  input logic req_accept,
  input logic rsp_valid,
  input logic done_valid,
  input logic retry
);
  // R2: no request leaves while the block is idle
  assert_idle_no_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
    acc_ready |-> !req_valid);

  // R3: two back-to-back requests only if the first was accepted
  assert_hi_after_accept_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && $past(req_valid)) |-> $past(req_accept));

  // R5: retry is caused by a refusal one cycle earlier
  assert_retry_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    retry |-> $past(req_valid && !req_accept));

  // R7: completion is a single-cycle pulse
  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |=> !done_valid);

  // R7: completion follows a response or a high-part drop
  assert_done_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |-> $past(rsp_valid || (req_valid && !req_accept)));
endmodule

bind split_access_tracker sat_checker i_sat_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .acc_ready (acc_ready),
  .req_valid (req_valid),
  .req_accept(req_accept),
  .rsp_valid (rsp_valid),
  .done_valid(done_valid),
  .retry     (retry)
);

// File: tb/test_split_access_tracker.sv
module test_split_access_tracker;
  localparam int DATA_BYTES = 8;
  localparam int TAG_W      = 4;
  localparam int ADDR_W     = 16;
  localparam int SIZE_W     = 4;
  localparam int DATA_W     = 64;
  localparam logic [63:0] JUNK = 64'hA5A5_A5A5_A5A5_A5A5;

  typedef struct packed {
    logic [15:0] addr;
    logic [3:0]  tag;
    logic [3:0]  size;
    logic [3:0]  lo;
    logic [63:0] data;
    logic        ref_lo;
    logic        ref_hi;
    logic        hi_first;
    logic        lo_early;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{16'h1000, 4'h1, 4'd8, 4'd0, 64'h1122_3344_5566_7788, 1'b0, 1'b0, 1'b0, 1'b0},
    '{16'h2003, 4'h2, 4'd3, 4'd0, 64'h0BAD_F00D_CAFE_BEEF, 1'b0, 1'b0, 1'b0, 1'b0},
    '{16'h3005, 4'h3, 4'd8, 4'd3, 64'h0102_0304_0506_0708, 1'b0, 1'b0, 1'b0, 1'b0},
    '{16'h40FB, 4'h4, 4'd6, 4'd5, 64'h9988_7766_5544_3322, 1'b0, 1'b0, 1'b1, 1'b0},
    '{16'h503E, 4'h5, 4'd4, 4'd2, 64'hDEAD_BEEF_1234_5678, 1'b0, 1'b0, 1'b0, 1'b1},
    '{16'h607C, 4'h6, 4'd8, 4'd4, 64'hF0E1_D2C3_B4A5_9687, 1'b0, 1'b1, 1'b0, 1'b0},
    '{16'h703F, 4'h7, 4'd2, 4'd1, 64'h0000_0000_0000_ABCD, 1'b1, 1'b0, 1'b0, 1'b0},
    '{16'h8010, 4'h8, 4'd4, 4'd0, 64'h0000_0000_1357_9BDF, 1'b1, 1'b0, 1'b0, 1'b0},
    '{16'h903A, 4'h9, 4'd8, 4'd6, 64'h2468_ACE0_1357_9BDF, 1'b0, 1'b1, 1'b0, 1'b1},
    '{16'hA039, 4'hA, 4'd8, 4'd7, 64'h7766_5544_3322_1100, 1'b0, 1'b0, 1'b1, 1'b1}
  };

  logic              clk = 1'b0;
  logic              rst_n;
  logic              acc_valid;
  logic              acc_ready;
  logic [ADDR_W-1:0] acc_addr;
  logic [TAG_W-1:0]  acc_tag;
  logic [SIZE_W-1:0] acc_size;
  logic [SIZE_W-1:0] acc_lo_size;
  logic              req_valid;
  logic [ADDR_W-1:0] req_addr;
  logic [SIZE_W-1:0] req_size;
  logic              req_accept;
  logic              rsp_valid;
  logic              rsp_part;
  logic [DATA_W-1:0] rsp_data;
  logic              done_valid;
  logic [TAG_W-1:0]  done_tag;
  logic [DATA_W-1:0] done_data;
  logic              done_partial;
  logic              retry;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  split_access_tracker #(.DATA_BYTES(DATA_BYTES), .TAG_W(TAG_W), .ADDR_W(ADDR_W)) i_split_access_tracker (
    .clk(clk), .rst_n(rst_n),
    .acc_valid(acc_valid), .acc_ready(acc_ready), .acc_addr(acc_addr), .acc_tag(acc_tag),
    .acc_size(acc_size), .acc_lo_size(acc_lo_size),
    .req_valid(req_valid), .req_addr(req_addr), .req_size(req_size), .req_accept(req_accept),
    .rsp_valid(rsp_valid), .rsp_part(rsp_part), .rsp_data(rsp_data),
    .done_valid(done_valid), .done_tag(done_tag), .done_data(done_data),
    .done_partial(done_partial), .retry(retry)
  );

  task automatic chk(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  function automatic logic [63:0] mask(input int n);
    if (n >= 8) return '1;
    return (64'd1 << (8 * n)) - 64'd1;
  endfunction

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  task automatic send_rsp(input logic part, input logic [63:0] payload);
    rsp_valid = 1'b1;
    rsp_part  = part;
    rsp_data  = payload;
  endtask

  task automatic run_vec(input vec_t v);
    bit split;
    bit pend_lo, pend_hi;
    int lolen, hilen;
    logic [63:0] lo_pay, hi_pay, exp;
    split  = (v.lo != 0);
    lolen  = split ? int'(v.lo) : int'(v.size);
    hilen  = int'(v.size) - int'(v.lo);
    lo_pay = (v.data & mask(lolen)) | (JUNK & ~mask(lolen));
    hi_pay = ((v.data >> (8 * int'(v.lo))) & mask(hilen)) | (JUNK & ~mask(hilen));
    exp    = v.data & mask(v.ref_hi ? int'(v.lo) : int'(v.size));

    @(negedge clk);
    chk(acc_ready == 1'b1, "R2 ready before access", 64'(acc_ready), 64'd1);
    acc_valid = 1'b1; acc_addr = v.addr; acc_tag = v.tag;
    acc_size = v.size; acc_lo_size = v.lo;
    @(posedge clk);
    @(negedge clk);
    acc_valid = 1'b0;
    chk(req_valid == 1'b1, "R2 first request valid", 64'(req_valid), 64'd1);
    chk(req_addr == v.addr, "R2 first request addr", 64'(req_addr), 64'(v.addr));
    chk(req_size == SIZE_W'(lolen), "R2 first request size", 64'(req_size), 64'(lolen));
    req_accept = !v.ref_lo;
    @(posedge clk);
    @(negedge clk);
    req_accept = 1'b0;
    if (v.ref_lo) begin
      chk(retry == 1'b1, "R5 retry after low refusal", 64'(retry), 64'd1);
      chk(acc_ready == 1'b1, "R5 idle after low refusal", 64'(acc_ready), 64'd1);
      chk(req_valid == 1'b0, "R5 no high send after low refusal", 64'(req_valid), 64'd0);
      for (int k = 0; k < 3; k++) begin
        chk(done_valid == 1'b0, "R5 no completion for dropped access", 64'(done_valid), 64'd0);
        @(posedge clk);
        @(negedge clk);
      end
      return;
    end
    pend_lo = 1'b1;
    pend_hi = split;
    if (split) begin
      chk(req_valid == 1'b1, "R3 high request valid", 64'(req_valid), 64'd1);
      chk(req_addr == v.addr + 16'(v.lo), "R3 high request addr", 64'(req_addr), 64'(v.addr + 16'(v.lo)));
      chk(req_size == SIZE_W'(hilen), "R3 high request size", 64'(req_size), 64'(hilen));
      req_accept = !v.ref_hi;
      if (v.lo_early) send_rsp(1'b0, lo_pay);
      @(posedge clk);
      @(negedge clk);
      req_accept = 1'b0;
      rsp_valid  = 1'b0;
      if (v.lo_early) pend_lo = 1'b0;
      if (v.ref_hi) begin
        pend_hi = 1'b0;
        chk(retry == 1'b1, "R6 retry after high refusal", 64'(retry), 64'd1);
      end
    end
    while (pend_lo || pend_hi) begin
      chk(done_valid == 1'b0, "R7 no early completion", 64'(done_valid), 64'd0);
      acc_valid = 1'b1; acc_tag = ~v.tag; acc_addr = 16'hFFFF;
      chk(acc_ready == 1'b0, "R2 busy ignores offers", 64'(acc_ready), 64'd0);
      if ((v.hi_first && pend_hi) || !pend_lo) begin
        send_rsp(1'b1, hi_pay);
        pend_hi = 1'b0;
      end else begin
        send_rsp(1'b0, lo_pay);
        pend_lo = 1'b0;
      end
      @(posedge clk);
      @(negedge clk);
      rsp_valid = 1'b0;
    end
    acc_valid = 1'b0;
    chk(done_valid == 1'b1, "R7 completion pulse", 64'(done_valid), 64'd1);
    chk(done_tag == v.tag, "R7 completion tag", 64'(done_tag), 64'(v.tag));
    chk(done_data == exp, v.ref_hi ? "R6 partial data" : "R4 assembled data", done_data, exp);
    chk(done_partial == v.ref_hi, "R6 partial flag", 64'(done_partial), 64'(v.ref_hi));
    @(posedge clk);
    @(negedge clk);
    chk(done_valid == 1'b0, "R7 completion lasts one cycle", 64'(done_valid), 64'd0);
    chk(acc_ready == 1'b1, "R7 idle after completion", 64'(acc_ready), 64'd1);
  endtask

  initial begin
    int cyc = 0;
    while (cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=done", cyc);
    finish_run();
  end

  initial begin
    rst_n = 1'b0; acc_valid = 1'b0; acc_addr = '0; acc_tag = '0; acc_size = '0;
    acc_lo_size = '0; req_accept = 1'b0; rsp_valid = 1'b0; rsp_part = 1'b0; rsp_data = '0;
    repeat (3) @(negedge clk);
    chk(acc_ready == 1'b1 && req_valid == 1'b0, "R1 idle in reset", 64'({acc_ready, req_valid}), 64'b10);
    chk(done_valid == 1'b0 && retry == 1'b0, "R1 no pulses in reset", 64'({done_valid, retry}), 64'b00);
    rst_n = 1'b1;
    @(negedge clk);
    chk(acc_ready == 1'b1 && req_valid == 1'b0, "R1 idle after reset", 64'({acc_ready, req_valid}), 64'b10);

    for (int i = 0; i < NV; i++) run_vec(VECS[i]);

    // R1: reset during an outstanding split access
    @(negedge clk);
    acc_valid = 1'b1; acc_addr = 16'h1234; acc_tag = 4'hC; acc_size = 4'd8; acc_lo_size = 4'd3;
    @(posedge clk);
    @(negedge clk);
    acc_valid = 1'b0;
    req_accept = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_accept = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    chk(acc_ready == 1'b1 && req_valid == 1'b0, "R1 mid-access reset idle", 64'({acc_ready, req_valid}), 64'b10);
    chk(done_data == 64'd0, "R1 buffer cleared by reset", done_data, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(done_valid == 1'b0 && retry == 1'b0, "R1 quiet after reset", 64'({done_valid, retry}), 64'b00);

    // R4: a plain access after reset still assembles correctly
    run_vec('{16'hB000, 4'hB, 4'd5, 4'd0, 64'h0000_00EE_DDCC_BBAA, 1'b0, 1'b0, 1'b0, 1'b0});

    finish_run();
  end
endmodule